// File: doc/BRIEF.md
# Camera Frame Grabber with Byte Pairing

This block sits between a camera sensor with an 8-bit pixel bus and an external SRAM. On request, it captures one complete video frame. It combines each two consecutive bytes of a line into one 16-bit pixel word. Each finished word is handed to the SRAM together with a write strobe and an address-advance strobe. An external address counter is cleared by a one-cycle strobe when the request is accepted, so every frame lands at address 0 onward.

All logic runs on the sensor's pixel clock. A request only arms the block. Data is taken from the first frame whose frame-valid signal rises after that, so a frame that is already in progress is skipped. Within the frame, only bytes sampled while line-valid is high are used. When frame-valid goes low between lines, the capture ends. A done flag then stays high until the requester withdraws the request.

Top module: `pix_frame_capture`

## Requirements
- R1: While reset is asserted, and after it is released, `pix_word_o` is zero and `wr_en_o`, `addr_inc_o`, `addr_clr_o` and `done_o` are low until a request arrives.
- R2: A request seen while idle produces exactly one `addr_clr_o` pulse, one cycle long, in the cycle after the edge that accepted it. No write happens in that cycle.
- R3: After arming, no byte is taken until `fv_i` has been sampled low and then high. A frame whose `fv_i` was already high when the request arrived contributes no words.
- R4: Bytes are taken only on rising clock edges where `lv_i` is high. The first byte of each pair fills bits 15:8 and the second fills bits 7:0. For 5-6-5 colour, this places red in 15:11, green in 10:5 and blue in 4:0.
- R5: For each completed pair, `wr_en_o` and `addr_inc_o` are high together for exactly one cycle, in the cycle after the edge that took the second byte, with the word on `pix_word_o`.
- R6: A falling `lv_i` returns the block to waiting for the next line rather than ending the frame. A trailing unpaired byte is discarded, and the next line starts again at bits 15:8.
- R7: If `fv_i` is low while the block waits for a line, it stops capturing and raises `done_o`. No write occurs while `done_o` is high, and a frame with no lines gives zero writes.
- R8: `done_o` stays high as long as the request stays high. It drops one cycle after the request is removed, and a later request captures a new frame starting again from address 0.
- R9: Without a request, frames on the sensor bus produce no write, clear or done activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req_i | input | 1 | Capture request, held high until done is seen |
| fv_i | input | 1 | Frame valid from the sensor |
| lv_i | input | 1 | Line valid from the sensor |
| byte_i | input | 8 | Sensor data byte |
| pix_word_o | output | 16 | Assembled pixel word for the SRAM data bus |
| wr_en_o | output | 1 | SRAM write enable, one cycle per word |
| addr_clr_o | output | 1 | Clears the external SRAM address counter |
| addr_inc_o | output | 1 | Advances the external SRAM address counter |
| done_o | output | 1 | Frame captured; held until the request drops |

## Verification
The bench goes after several ways a grabber can fail.

- A request that lands in the middle of a frame: a grabber that started on the frame-valid level instead of its rising edge would write a partial frame first.
- Lines with an odd byte count: a design that kept the stray byte would pair it with the next line and shift every later word's halves.
- An empty frame: this checks that the grabber finishes instead of hanging.
- A second capture after done: a missing clear or a sticky done would show up as data at the wrong addresses or a capture that never restarts.
- Byte order: the expected words are rebuilt from the driven bytes, so swapped halves show up immediately.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [2:0] {
        CAP_IDLE = 3'd0,
        CAP_ARM  = 3'd1,
        CAP_GAP  = 3'd2,
        CAP_HALF = 3'd3,
        CAP_FIN  = 3'd4
    } cap_state_e;

    typedef struct packed {
        cap_state_e st;
        logic       clr;
    } ctrl_regs_t;

endpackage

// File: rtl/pfc_edge.sv
module pfc_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (RISE) begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & prev_q;
        end
    endgenerate

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o) else $error("edge flagged twice"); // R3

endmodule

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fv_i,
    input  logic fv_rise_i,
    input  logic lv_i,
    output logic take_first_o,
    output logic take_second_o,
    output logic clr_o,
    output logic done_o
);

    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d        = regs_q;
        regs_d.clr    = 1'b0;
        take_first_o  = 1'b0;
        take_second_o = 1'b0;
        unique case (regs_q.st)
            CAP_IDLE: begin
                if (req_i) begin
                    regs_d.st  = CAP_ARM;
                    regs_d.clr = 1'b1;
                end
            end
            CAP_ARM: begin
                if (fv_rise_i) regs_d.st = CAP_GAP;
            end
            CAP_GAP: begin
                if (!fv_i) begin
                    regs_d.st = CAP_FIN;
                end else if (lv_i) begin
                    take_first_o = 1'b1;
                    regs_d.st    = CAP_HALF;
                end
            end
            CAP_HALF: begin
                take_second_o = lv_i;
                regs_d.st     = CAP_GAP;
            end
            CAP_FIN: begin
                if (!req_i) regs_d.st = CAP_IDLE;
            end
            default: regs_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st  <= CAP_IDLE;
            regs_q.clr <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign clr_o  = regs_q.clr;
    assign done_o = (regs_q.st == CAP_FIN);

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o) else $error("clear longer than one cycle"); // R2
    AST_CLR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> $past(req_i)) else $error("clear without request"); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && req_i) |=> done_o) else $error("done dropped early"); // R8

endmodule

// File: rtl/pfc_pack.sv
module pfc_pack #(
    parameter int BYTE_W   = 8,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_first_i,
    input  logic                  take_second_i,
    input  logic [BYTE_W-1:0]     byte_i,
    output logic [2*BYTE_W-1:0]   word_o,
    output logic                  wr_o
);

    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic [WORD_W-1:0] word;
        logic              wr;
    } pack_regs_t;

    pack_regs_t        regs_d, regs_q;
    logic [WORD_W-1:0] joined;

    generate
        if (HI_FIRST) begin : g_hi_first
            assign joined = {regs_q.hold, byte_i};
        end else begin : g_lo_first
            assign joined = {byte_i, regs_q.hold};
        end
    endgenerate

    always_comb begin
        regs_d    = regs_q;
        regs_d.wr = 1'b0;
        if (take_first_i) regs_d.hold = byte_i;
        if (take_second_i) begin
            regs_d.word = joined;
            regs_d.wr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign word_o = regs_q.word;
    assign wr_o   = regs_q.wr;

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_first_i && take_second_i)) else $error("both halves taken at once"); // R4

endmodule

// File: rtl/pix_frame_capture.sv
module pix_frame_capture #(
    parameter int BYTE_W   = 8,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_req_i,
    input  logic                fv_i,
    input  logic                lv_i,
    input  logic [BYTE_W-1:0]   byte_i,
    output logic [2*BYTE_W-1:0] pix_word_o,
    output logic                wr_en_o,
    output logic                addr_clr_o,
    output logic                addr_inc_o,
    output logic                done_o
);

    logic fv_rise;
    logic take_first;
    logic take_second;
    logic word_wr;

    pfc_edge #(.RISE(1'b1)) u_fv_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (fv_i),
        .edge_o (fv_rise)
    );

    pfc_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (cap_req_i),
        .fv_i          (fv_i),
        .fv_rise_i     (fv_rise),
        .lv_i          (lv_i),
        .take_first_o  (take_first),
        .take_second_o (take_second),
        .clr_o         (addr_clr_o),
        .done_o        (done_o)
    );

    pfc_pack #(.BYTE_W(BYTE_W), .HI_FIRST(HI_FIRST)) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_first_i  (take_first),
        .take_second_i (take_second),
        .byte_i        (byte_i),
        .word_o        (pix_word_o),
        .wr_o          (word_wr)
    );

    assign wr_en_o    = word_wr;
    assign addr_inc_o = word_wr;

    AST_WR_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(lv_i)) else $error("write without line data"); // R4
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o) else $error("write while done"); // R7
    AST_CLR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clr_o |-> !wr_en_o) else $error("write during clear"); // R2

endmodule

// File: tb/tb_pix_frame_capture.sv
`timescale 1ns/1ps
module tb_pix_frame_capture;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, fv, lv;
    logic [7:0]  din;
    logic [15:0] word;
    logic        wr_en, clr, inc, done;

    always #2.5 clk = ~clk;

    pix_frame_capture dut (
        .clk(clk), .rst_n(rst_n), .cap_req_i(req), .fv_i(fv), .lv_i(lv),
        .byte_i(din), .pix_word_o(word), .wr_en_o(wr_en), .addr_clr_o(clr),
        .addr_inc_o(inc), .done_o(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem [0:63];
    int waddr = 0;
    int wr_cnt = 0;
    int clr_cnt = 0;
    logic [15:0] exp_q [$];

    task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // SRAM model with external address counter, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (inc !== wr_en) begin
                n_chk++; n_bad++;
                $display("FAIL R5 actual=%0b expected=%0b (addr_inc vs wr_en)", inc, wr_en);
            end
            if (clr) begin
                clr_cnt++;
                waddr = 0;
            end else if (wr_en) begin
                if (waddr < 64) mem[waddr] = word;
                waddr++;
                wr_cnt++;
            end
        end
    end

    function automatic logic [7:0] byte_of(input int seed, input int ln, input int b);
        return 8'((seed * 53 + ln * 17 + b * 3 + 1) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        wr_cnt = 0;
        clr_cnt = 0;
        exp_q.delete();
    endtask

    task automatic drive_line(input int seed, input int ln, input int nbytes, input bit record);
        for (int b = 0; b < nbytes; b++) begin
            lv  = 1'b1;
            din = byte_of(seed, ln, b);
            tick(1);
        end
        lv  = 1'b0;
        din = 8'h00;
        tick(3);
        if (record)
            for (int k = 0; k < nbytes / 2; k++)
                exp_q.push_back({byte_of(seed, ln, 2 * k), byte_of(seed, ln, 2 * k + 1)});
    endtask

    task automatic drive_frame(input int seed, input int nlines, input int nbytes, input bit record);
        fv = 1'b1;
        tick(2);
        for (int ln = 0; ln < nlines; ln++) drive_line(seed, ln, nbytes, record);
        fv = 1'b0;
        tick(3);
    endtask

    task automatic cmp_mem(input string req_tag);
        check(req_tag, wr_cnt, exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) check(req_tag, mem[i], exp_q[i]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = 1'b0; fv = 1'b0; lv = 1'b0; din = 8'h00;
        tick(4);
        check("R1", {word, wr_en, inc, clr, done}, 20'h0);
        rst_n = 1'b1;
        tick(3);
        check("R1", {word, wr_en, inc, clr, done}, 20'h0);
    endtask

    task automatic t_basic();
        clear_log();
        req = 1'b1;
        tick(1);
        check("R2", clr, 1'b1);
        tick(1);
        check("R2", clr, 1'b0);
        drive_frame(1, 3, 8, 1'b1);
        tick(2);
        check("R7", done, 1'b1);
        check("R2", clr_cnt, 1);
        cmp_mem("R5");
        check("R4", mem[0], {byte_of(1, 0, 0), byte_of(1, 0, 1)});
    endtask

    task automatic t_done_hold();
        tick(10);
        check("R8", done, 1'b1);
        req = 1'b0;
        tick(1);
        check("R8", done, 1'b0);
        tick(2);
    endtask

    task automatic t_in_progress();
        clear_log();
        fv = 1'b1;
        tick(2);
        req = 1'b1;
        tick(2);
        drive_line(9, 0, 6, 1'b0);
        fv = 1'b0;
        tick(3);
        check("R3", wr_cnt, 0);
        check("R3", done, 1'b0);
        drive_frame(2, 2, 6, 1'b1);
        tick(2);
        cmp_mem("R3");
        check("R8", clr_cnt, 1);
        req = 1'b0;
        tick(2);
    endtask

    task automatic t_odd();
        clear_log();
        req = 1'b1;
        tick(2);
        drive_frame(3, 3, 5, 1'b1);
        tick(2);
        cmp_mem("R6");
        check("R6", mem[2], {byte_of(3, 1, 0), byte_of(3, 1, 1)});
        check("R8", clr_cnt, 1);
        req = 1'b0;
        tick(2);
    endtask

    task automatic t_empty();
        clear_log();
        req = 1'b1;
        tick(2);
        fv = 1'b1;
        tick(4);
        fv = 1'b0;
        tick(3);
        check("R7", done, 1'b1);
        check("R7", wr_cnt, 0);
        req = 1'b0;
        tick(2);
        check("R8", done, 1'b0);
    endtask

    task automatic t_noreq();
        clear_log();
        drive_frame(4, 2, 4, 1'b0);
        tick(2);
        check("R9", wr_cnt, 0);
        check("R9", clr_cnt, 0);
        check("R9", done, 1'b0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_done_hold();
        t_in_progress();
        t_odd();
        t_empty();
        t_noreq();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule